// File: doc/BRIEF.md
# BCD Calendar Clock with Exact-Match Alarm

This block keeps wall-clock time as packed BCD bytes: seconds, minutes, hours (24-hour), day of month, month, a two-digit year and a weekday counter. A single-cycle tick enable, nominally at 32768 Hz, drives a prescaler. When the prescaler reaches the parameterised tick count, the time advances by one second. The increment handles the full calendar: month lengths, leap years and the wrap from year 99 to year 00.

Software reaches the block through a byte-oriented register file on a simple synchronous write port with a combinational read port. Every register except the two key words is write-protected until a two-word unlock sequence has been written. A status byte reports a busy window just before each seconds update, a run flag, sticky rollover events, an alarm flag and a power-up flag. The alarm flag is set only when all six alarm fields equal the current time, and there are no wildcard fields. Three level outputs give a periodic interrupt, an alarm interrupt and an alarm wakeup. Each output is a status flag gated by its own enable bit.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads 00:00:00 on day 0x01, month 0x01, year 0x00, with weekday 0. Status reads 0x80, meaning only the power-up flag (bit 7) is set. All three outputs are low.
- R2: A write to any address other than 0x6C or 0x70 is ignored unless the block is unlocked.
  - Unlocking takes 0x83E70B13 written to 0x6C, followed by 0x95A4F1E0 written to 0x70.
  - Any other value written to 0x6C, including 0, locks the block.
  - A write to 0x70 that does not directly follow the first key word leaves the block locked.
- R3: A tick is accepted only while control bit 0 (run) and oscillator bit 6 (clock enable) are both 1. The seconds field advances once per TICKS_PER_SEC accepted ticks. Status bit 1 mirrors control bit 0.
- R4: Status bit 0 (busy) is high from the accepted tick that leaves one tick before a seconds update until the tick that performs the update. It is low after the update.
- R5: The fields are BCD. Seconds and minutes wrap 0x59 to 0x00 with a carry, and hours wrap 0x23 to 0x00 with a carry. A units digit of 9 carries into the tens digit. The weekday (address 0x18) counts 0 to 6 on each day carry and wraps to 0.
- R6: The day wraps to 0x01 after the last day of the month:
  - February ends at 0x29 when the year is divisible by 4 (year 00 counts as a leap year) and at 0x28 otherwise.
  - April, June, September and November end at 0x30.
  - All other months end at 0x31.
- R7: Month wraps 0x12 to 0x01 and carries into the year. Month 0x09 steps to 0x10. Year wraps 0x99 to 0x00.
- R8: Status bits 2, 3, 4 and 5 become set when the seconds, minutes, hours and day fields advance, respectively. Writing 1 to any of status bits 2 to 7 clears that bit, and writing 0 leaves it unchanged.
- R9: Status bit 6 (alarm) is set one cycle after a seconds update that leaves all six time fields equal to the alarm fields at 0x20, 0x24, 0x28, 0x2C, 0x30 and 0x34 (seconds first, year last). A register write that makes the fields equal does not set the flag, and one mismatching field keeps it clear.
- R10: The outputs are driven as follows:
  - irq_tick = status bit 2 AND bit 2 of the enable register at 0x48.
  - irq_alarm = status bit 6 AND bit 3 of 0x48.
  - wake_alarm = status bit 6 AND bit 1 of the wake register at 0x7C.
- R11: Readback keeps only these bits: control (0x40) bits 0, 2, 3 and 7; the oscillator register (0x54) bit 6; the enable register bits 2 and 3; the wake register bit 1. Time fields live at 0x00 to 0x14 in steps of 4, seconds first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per oscillator period |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (key words use all 32 bits, other registers use bits 7:0) |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_tick | output | 1 | Periodic interrupt level |
| irq_alarm | output | 1 | Alarm interrupt level |
| wake_alarm | output | 1 | Alarm wakeup level |

## Verification
The bench instantiates the block with TICKS_PER_SEC set to 4, so each simulated second is four tick pulses. This brings the busy window, the seconds update and every calendar carry within a few dozen clock cycles. Each carry case is reached by writing a preset date one second before the boundary and issuing a single second's worth of ticks. The cases covered are February in leap and common years, 30-day months, a 31-day month that must not roll at day 30, September to October, and the year 99 wrap. The alarm is placed one second ahead with one field wrong and then with all fields right, so both the mismatch and the exact-match path are exercised at an update.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    // Register byte addresses
    localparam logic [7:0] A_SEC   = 8'h00;
    localparam logic [7:0] A_WDAY  = 8'h18;
    localparam logic [7:0] A_ALM0  = 8'h20;
    localparam logic [7:0] A_CTRL  = 8'h40;
    localparam logic [7:0] A_STAT  = 8'h44;
    localparam logic [7:0] A_IEN   = 8'h48;
    localparam logic [7:0] A_OSC   = 8'h54;
    localparam logic [7:0] A_KEYA  = 8'h6C;
    localparam logic [7:0] A_KEYB  = 8'h70;
    localparam logic [7:0] A_WAKE  = 8'h7C;

    localparam logic [31:0] KEY_A = 32'h83E7_0B13;
    localparam logic [31:0] KEY_B = 32'h95A4_F1E0;

    localparam int unsigned NFIELD = 6;

    // Readback masks
    localparam logic [7:0] CTRL_MASK = 8'h8D;
    localparam logic [7:0] OSC_MASK  = 8'h40;
    localparam logic [7:0] IEN_MASK  = 8'h0C;
    localparam logic [7:0] WAKE_MASK = 8'h02;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] day;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    typedef logic [NFIELD-1:0][7:0] rtc_fields_t;

    localparam rtc_fields_t FIELD_RST = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    // Carries produced by one seconds update
    typedef struct packed {
        logic min;
        logic hr;
        logic day;
    } carry_t;

    // Sticky status flags (status byte bits 7..2)
    typedef struct packed {
        logic pwr;
        logic alm;
        logic ev_day;
        logic ev_hr;
        logic ev_min;
        logic ev_sec;
    } flags_t;

    typedef enum logic [1:0] {
        LK_SHUT,
        LK_ARMED,
        LK_OPEN
    } lock_e;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    endfunction

    function automatic logic leap_year(input logic [7:0] yr);
        logic [7:0] b;
        b = bcd_to_bin(yr);
        return b[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
    parameter int unsigned TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic enable,
    output logic busy_o,
    output logic sec_adv_o
);
    localparam int unsigned CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;
    logic          take;

    assign take      = tick_en && enable;
    assign sec_adv_o = take && (cnt_q == LAST);
    assign busy_o    = enable && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else if (take) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    p_adv_restarts_r4: assert property (@(posedge clk) disable iff (rst)
        sec_adv_o |=> (cnt_q == '0) && !busy_o);

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_adv,
    input  logic [NFIELD:0]   fld_we,
    input  logic [7:0]        wbyte,
    output rtc_time_t         now_o,
    output logic [2:0]        wday_o,
    output carry_t            carry_o
);
    rtc_fields_t fld_q;
    rtc_time_t   now;
    rtc_time_t   nxt;
    rtc_fields_t nxt_f;
    logic [2:0]  wday_q;
    logic [2:0]  wday_n;
    carry_t      cy;

    assign now   = rtc_time_t'(fld_q);
    assign nxt_f = rtc_fields_t'(nxt);

    always_comb begin
        nxt    = now;
        wday_n = wday_q;
        cy     = '0;
        if (now.sec != 8'h59) begin
            nxt.sec = bcd_inc(now.sec);
        end else begin
            nxt.sec = 8'h00;
            cy.min  = 1'b1;
            if (now.min != 8'h59) begin
                nxt.min = bcd_inc(now.min);
            end else begin
                nxt.min = 8'h00;
                cy.hr   = 1'b1;
                if (now.hr != 8'h23) begin
                    nxt.hr = bcd_inc(now.hr);
                end else begin
                    nxt.hr = 8'h00;
                    cy.day = 1'b1;
                    wday_n = (wday_q >= 3'd6) ? 3'd0 : wday_q + 3'd1;
                    if (now.day != month_last(now.mon, now.yr)) begin
                        nxt.day = bcd_inc(now.day);
                    end else begin
                        nxt.day = 8'h01;
                        if (now.mon != 8'h12) begin
                            nxt.mon = bcd_inc(now.mon);
                        end else begin
                            nxt.mon = 8'h01;
                            nxt.yr  = (now.yr == 8'h99) ? 8'h00 : bcd_inc(now.yr);
                        end
                    end
                end
            end
        end
    end

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst)            fld_q[i] <= FIELD_RST[i];
            else if (fld_we[i]) fld_q[i] <= wbyte;
            else if (sec_adv)   fld_q[i] <= nxt_f[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 wday_q <= 3'd0;
        else if (fld_we[NFIELD]) wday_q <= wbyte[2:0];
        else if (sec_adv)        wday_q <= wday_n;
    end

    assign now_o   = now;
    assign wday_o  = wday_q;
    assign carry_o = sec_adv ? cy : '0;

    p_sec_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        sec_adv && (fld_we == '0) && (now.sec == 8'h59) |=> (now.sec == 8'h00));

    p_leap_feb_r6: assert property (@(posedge clk) disable iff (rst)
        sec_adv && (fld_we == '0) && (now[39:0] == 40'h02_28_23_59_59) && (now.yr == 8'h23)
        |=> (now.day == 8'h01) && (now.mon == 8'h03));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sec_adv,
    input  rtc_time_t now,
    input  rtc_time_t alm,
    output logic      hit_o
);
    logic adv_d;

    always_ff @(posedge clk) begin
        if (rst) adv_d <= 1'b0;
        else     adv_d <= sec_adv;
    end

    // Compare only in the cycle after an update: fields are fresh, and
    // a stable equal value cannot re-raise the flag after it is cleared.
    assign hit_o = adv_d && (now == alm);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 32768
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_tick,
    output logic        irq_alarm,
    output logic        wake_alarm
);
    lock_e       lock_q;
    logic        wr_ok;
    logic [7:0]  ctrl_q, osc_q, ien_q, wake_q;
    flags_t      flg_q, flg_n;
    rtc_fields_t alm_q;
    logic [NFIELD:0] fld_we;
    logic        running, busy, sec_adv, hit;
    rtc_time_t   now;
    rtc_fields_t now_f;
    logic [2:0]  wday;
    carry_t      cy;
    logic [7:0]  stat_byte;

    assign wr_ok   = bus_wr && (lock_q == LK_OPEN);
    assign running = ctrl_q[0] && osc_q[6];
    assign now_f   = rtc_fields_t'(now);

    // Unlock sequence
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= LK_SHUT;
        end else if (bus_wr && bus_addr == A_KEYA) begin
            lock_q <= (bus_wdata == KEY_A) ? LK_ARMED : LK_SHUT;
        end else if (bus_wr && bus_addr == A_KEYB) begin
            if (lock_q == LK_ARMED) lock_q <= (bus_wdata == KEY_B) ? LK_OPEN : LK_SHUT;
        end
    end

    // Field write strobes
    always_comb begin
        for (int i = 0; i < NFIELD; i++)
            fld_we[i] = wr_ok && (bus_addr == 8'(4 * i));
        fld_we[NFIELD] = wr_ok && (bus_addr == A_WDAY);
    end

    // Control, enables and alarm fields
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            osc_q  <= '0;
            ien_q  <= '0;
            wake_q <= '0;
            alm_q  <= '0;
        end else if (wr_ok) begin
            case (bus_addr)
                A_CTRL:  ctrl_q <= bus_wdata[7:0] & CTRL_MASK;
                A_OSC:   osc_q  <= bus_wdata[7:0] & OSC_MASK;
                A_IEN:   ien_q  <= bus_wdata[7:0] & IEN_MASK;
                A_WAKE:  wake_q <= bus_wdata[7:0] & WAKE_MASK;
                default: ;
            endcase
            for (int i = 0; i < NFIELD; i++)
                if (bus_addr == A_ALM0 + 8'(4 * i)) alm_q[i] <= bus_wdata[7:0];
        end
    end

    // Status flags: set wins over a same-cycle clear
    always_comb begin
        flg_n = flg_q;
        if (wr_ok && bus_addr == A_STAT) flg_n = flg_q & ~flags_t'(bus_wdata[7:2]);
        flg_n.ev_sec = flg_n.ev_sec | sec_adv;
        flg_n.ev_min = flg_n.ev_min | cy.min;
        flg_n.ev_hr  = flg_n.ev_hr  | cy.hr;
        flg_n.ev_day = flg_n.ev_day | cy.day;
        flg_n.alm    = flg_n.alm    | hit;
    end

    always_ff @(posedge clk) begin
        if (rst) flg_q <= '{pwr: 1'b1, default: 1'b0};
        else     flg_q <= flg_n;
    end

    assign stat_byte = {flg_q, ctrl_q[0], busy};

    rtc_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
        .clk(clk), .rst(rst), .tick_en(tick_en), .enable(running),
        .busy_o(busy), .sec_adv_o(sec_adv)
    );

    rtc_calendar_core u_core (
        .clk(clk), .rst(rst), .sec_adv(sec_adv), .fld_we(fld_we),
        .wbyte(bus_wdata[7:0]), .now_o(now), .wday_o(wday), .carry_o(cy)
    );

    rtc_alarm_match u_alm (
        .clk(clk), .rst(rst), .sec_adv(sec_adv), .now(now),
        .alm(rtc_time_t'(alm_q)), .hit_o(hit)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_WDAY: bus_rdata[2:0] = wday;
            A_CTRL: bus_rdata[7:0] = ctrl_q;
            A_STAT: bus_rdata[7:0] = stat_byte;
            A_IEN:  bus_rdata[7:0] = ien_q;
            A_OSC:  bus_rdata[7:0] = osc_q;
            A_WAKE: bus_rdata[7:0] = wake_q;
            default: ;
        endcase
        for (int i = 0; i < NFIELD; i++) begin
            if (bus_addr == 8'(4 * i))          bus_rdata[7:0] = now_f[i];
            if (bus_addr == A_ALM0 + 8'(4 * i)) bus_rdata[7:0] = alm_q[i];
        end
    end

    assign irq_tick   = flg_q.ev_sec && ien_q[2];
    assign irq_alarm  = flg_q.alm && ien_q[3];
    assign wake_alarm = flg_q.alm && wake_q[1];

    p_locked_write_r2: assert property (@(posedge clk) disable iff (rst)
        bus_wr && (lock_q != LK_OPEN) && (bus_addr == A_CTRL) |=> $stable(ctrl_q));

    p_alarm_after_adv_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(flg_q.alm) |-> $past(sec_adv, 2));

    p_pwr_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        wr_ok && (bus_addr == A_STAT) && bus_wdata[7] |=> !flg_q.pwr);

    p_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
        wr_ok && (bus_addr == A_IEN) && (bus_wdata[7:0] == 8'h00) |=> !irq_tick && !irq_alarm);

endmodule

// File: tb/rtc_calendar_test.sv
`timescale 1ns/1ps
module rtc_calendar_test;
    localparam int unsigned TPS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_tick, irq_alarm, wake_alarm;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        int          kind;   // 0 rdata, 1 irq_tick, 2 irq_alarm, 3 wake_alarm
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } item_t;
    item_t q[$];
    event sample_ev;

    always #4 clk = ~clk;

    rtc_calendar #(.TICKS_PER_SEC(TPS)) uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_tick(irq_tick), .irq_alarm(irq_alarm), .wake_alarm(wake_alarm)
    );

    // Monitor: pops expected items and compares against the ports
    initial forever begin
        item_t it;
        logic [31:0] act;
        @(sample_ev);
        while (q.size() > 0) begin
            it = q.pop_front();
            case (it.kind)
                1:       act = {31'd0, irq_tick};
                2:       act = {31'd0, irq_alarm};
                3:       act = {31'd0, wake_alarm};
                default: act = bus_rdata;
            endcase
            checks++;
            if ((act & it.mask) !== (it.exp & it.mask)) begin
                fails++;
                $display("FAIL %s: actual %h expected %h (mask %h)", it.tag,
                         act & it.mask, it.exp & it.mask, it.mask);
            end
        end
    end

    task automatic chk(input int kind, input logic [7:0] a, input logic [31:0] e,
                       input logic [31:0] m, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.kind = kind; it.exp = e; it.mask = m; it.tag = tag;
        q.push_back(it);
        #1;
        -> sample_ev;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        chk(0, a, {24'd0, e}, 32'hFF, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic setdate(input logic [7:0] y, mo, d, h, mi, s);
        wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d);
        wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, 8'h00, "R1 sec"); rd(8'h04, 8'h00, "R1 min"); rd(8'h08, 8'h00, "R1 hr");
        rd(8'h0C, 8'h01, "R1 day"); rd(8'h10, 8'h01, "R1 mon"); rd(8'h14, 8'h00, "R1 yr");
        rd(8'h18, 8'h00, "R1 wday"); rd(8'h44, 8'h80, "R1 status");
        chk(1, 8'h00, 0, 1, "R1 irq_tick"); chk(2, 8'h00, 0, 1, "R1 irq_alarm");
        chk(3, 8'h00, 0, 1, "R1 wake_alarm");

        // R2 lock
        wr(8'h00, 32'h30); rd(8'h00, 8'h00, "R2 locked write");
        wr(8'h70, 32'h95A4F1E0); wr(8'h00, 32'h30); rd(8'h00, 8'h00, "R2 key B alone");
        wr(8'h6C, 32'h83E70B13); wr(8'h70, 32'h95A4F1E0);
        wr(8'h00, 32'h30); rd(8'h00, 8'h30, "R2 unlocked write");

        // R11 readback masks
        wr(8'h40, 32'hFF); rd(8'h40, 8'h8D, "R11 ctrl");
        wr(8'h48, 32'hFF); rd(8'h48, 8'h0C, "R11 ien");
        wr(8'h48, 32'h00); wr(8'h40, 32'h00);

        // R3 run / oscillator gating
        wr(8'h40, 32'h01); chk(0, 8'h44, 32'h02, 32'h02, "R3 run bit");
        tick(4); rd(8'h00, 8'h30, "R3 osc off");
        wr(8'h54, 32'hFF); rd(8'h54, 8'h40, "R11 osc");

        // R4 busy window
        tick(3);
        chk(0, 8'h44, 32'h01, 32'h01, "R4 busy high"); rd(8'h00, 8'h30, "R3 no early step");
        tick(1);
        rd(8'h00, 8'h31, "R3 one second"); chk(0, 8'h44, 32'h00, 32'h01, "R4 busy low");

        wr(8'h40, 32'h00); tick(4);
        rd(8'h00, 8'h31, "R3 stopped"); chk(0, 8'h44, 32'h00, 32'h02, "R3 run clear");
        wr(8'h40, 32'h01);

        // R7 / R5 full rollover
        wr(8'h44, 32'h3C);
        setdate(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59); wr(8'h18, 32'h6);
        tick(4);
        rd(8'h14, 8'h00, "R7 year wrap"); rd(8'h10, 8'h01, "R7 month wrap");
        rd(8'h0C, 8'h01, "R6 day wrap"); rd(8'h08, 8'h00, "R5 hr wrap");
        rd(8'h04, 8'h00, "R5 min wrap"); rd(8'h00, 8'h00, "R5 sec wrap");
        rd(8'h18, 8'h00, "R5 wday wrap");
        chk(0, 8'h44, 32'h3C, 32'h3C, "R8 events set");
        wr(8'h44, 32'h14); chk(0, 8'h44, 32'h28, 32'h3C, "R8 w1c partial");
        wr(8'h44, 32'h00); chk(0, 8'h44, 32'h28, 32'h3C, "R8 write zero");
        wr(8'h44, 32'h3C);

        // R5 partial carries
        setdate(8'h05, 8'h06, 8'h15, 8'h10, 8'h59, 8'h59); tick(4);
        rd(8'h08, 8'h11, "R5 hr carry"); rd(8'h0C, 8'h15, "R5 day kept");
        setdate(8'h05, 8'h06, 8'h15, 8'h10, 8'h20, 8'h09); tick(4);
        rd(8'h00, 8'h10, "R5 units carry"); rd(8'h04, 8'h20, "R5 min kept");

        // R6 month lengths
        setdate(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); tick(4);
        rd(8'h0C, 8'h29, "R6 leap feb 29"); rd(8'h10, 8'h02, "R6 leap month kept");
        setdate(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59); tick(4);
        rd(8'h0C, 8'h01, "R6 leap end day"); rd(8'h10, 8'h03, "R6 leap end mon");
        setdate(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); tick(4);
        rd(8'h0C, 8'h01, "R6 common feb"); rd(8'h10, 8'h03, "R6 common mon");
        setdate(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); tick(4);
        rd(8'h0C, 8'h29, "R6 year 00 leap");
        setdate(8'h21, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59); tick(4);
        rd(8'h0C, 8'h01, "R6 april"); rd(8'h10, 8'h05, "R6 april mon");
        setdate(8'h21, 8'h09, 8'h30, 8'h23, 8'h59, 8'h59); tick(4);
        rd(8'h10, 8'h10, "R7 sep to oct"); rd(8'h0C, 8'h01, "R6 sep day");
        setdate(8'h21, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59); tick(4);
        rd(8'h0C, 8'h31, "R6 jan 31"); rd(8'h10, 8'h01, "R6 jan kept");

        // R9 alarm matching
        wr(8'h44, 32'h7C);
        setdate(8'h30, 8'h07, 8'h04, 8'h12, 8'h00, 8'h10);
        wr(8'h20, 32'h11); wr(8'h24, 32'h00); wr(8'h28, 32'h12);
        wr(8'h2C, 32'h04); wr(8'h30, 32'h07); wr(8'h34, 32'h31);
        rd(8'h34, 8'h31, "R11 alarm yr readback");
        tick(4); chk(0, 8'h44, 32'h00, 32'h40, "R9 year mismatch");
        wr(8'h34, 32'h30); chk(0, 8'h44, 32'h00, 32'h40, "R9 no match on write");
        wr(8'h20, 32'h12); tick(4);
        chk(0, 8'h44, 32'h40, 32'h40, "R9 exact match");

        // R10 outputs
        chk(2, 8'h00, 0, 1, "R10 alarm irq masked");
        wr(8'h48, 32'h08); chk(2, 8'h00, 1, 1, "R10 alarm irq");
        chk(3, 8'h00, 0, 1, "R10 wake masked");
        wr(8'h7C, 32'h02); chk(3, 8'h00, 1, 1, "R10 wake");
        wr(8'h44, 32'h40);
        chk(2, 8'h00, 0, 1, "R8 alarm w1c irq"); chk(3, 8'h00, 0, 1, "R8 alarm w1c wake");
        wr(8'h48, 32'h04); chk(1, 8'h00, 1, 1, "R10 tick irq");
        wr(8'h44, 32'h04); chk(1, 8'h00, 0, 1, "R10 tick cleared");
        tick(4); chk(1, 8'h00, 1, 1, "R10 tick again");
        wr(8'h48, 32'h00); chk(1, 8'h00, 0, 1, "R10 tick disabled");
        wr(8'h44, 32'h80); chk(0, 8'h44, 32'h00, 32'h80, "R8 power-up w1c");

        // R2 relock
        wr(8'h6C, 32'h0); wr(8'h00, 32'h45); rd(8'h00, 8'h13, "R2 relocked");
        wr(8'h6C, 32'h83E70B13); wr(8'h70, 32'h00001234);
        wr(8'h00, 32'h45); rd(8'h00, 8'h13, "R2 bad key B");

        repeat (2) @(negedge clk);
        done = 1;
        summary();
    end
endmodule